// File: doc/BRIEF.md
# Sequential Signed Booth Multiplier

This block multiplies two signed two's-complement words over several clock cycles with one adder/subtractor. A single wide shift register holds the running upper half of the product and the multiplier in its lower half, plus one extra bit that remembers the bit most recently shifted out. On each iteration the two lowest bits of that register choose among adding the multiplicand into the upper half, subtracting it, or leaving the upper half as it is. After that choice the whole register shifts right by one place, and the sign is copied into the top bit.

A client drives both operands and pulses `start` while the block is idle. `busy_o` stays high for the whole computation. When `done_o` pulses, the signed double-width product can be read from `hi_o` (upper word) and `lo_o` (lower word). Both words hold their values until the next multiply completes.

Top module: `booth_mul`

## Requirements
- R1: After reset, `busy_o` and `done_o` are low and `hi_o` and `lo_o` are zero.
- R2: When `start` is high at a clock edge while `busy_o` is low, the operands are captured at that edge and `busy_o` is high from that edge on. With a capture at edge t, `done_o` is high for exactly the one cycle after edge t+W, and `busy_o` falls at edge t+W.
- R3: When `done_o` is high, `{hi_o, lo_o}` equals the signed 2W-bit product of the captured `mcand_i` and `mplier_i`. `hi_o` is bits 2W-1..W of the product and `lo_o` is bits W-1..0.
- R4: The product is also correct when either operand, or both operands, equal the most negative value -2^(W-1). For example, (-2^31)·(-2^31) = 2^62.
- R5: A `start` pulse while `busy_o` is high has no effect. The running product and the completion cycle are unchanged, and so are the operands it was computing with.
- R6: `done_o` is never high on two consecutive cycles. `hi_o` and `lo_o` change only at the edge that raises `done_o`, and they keep their values until the next completion.
- R7: A new `start` may be given in the cycle where `done_o` is high, because `busy_o` is already low then. That multiply follows the same timing as R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiply when idle |
| mcand_i | input | W | Signed multiplicand |
| mplier_i | input | W | Signed multiplier |
| busy_o | output | 1 | Multiply in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hi_o | output | W | Upper word of product |
| lo_o | output | W | Lower word of product |

## Verification
Several properties are checked on every cycle: the one-cycle width of the completion pulse, that busy and done are never high together, that busy can drop only through completion, that the result words are stable outside a completion edge, and that the distance from an accepted start to done is exactly W+1 edges (counted by the checker). The numerical correctness of the product can only be shown by the bench's scenarios. These cover mixed signs, zero, all-ones, both most-negative corner cases, an ignored mid-run start, and a back-to-back restart, each compared with a product the bench computes itself.

// File: rtl/booth_pkg.sv
package booth_pkg;
  typedef enum logic [1:0] {
    OP_KEEP = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } booth_op_e;
endpackage

// File: rtl/booth_recode.sv
module booth_recode
  import booth_pkg::*;
(
  input  logic      cur_bit,
  input  logic      prev_bit,
  output booth_op_e op
);
  // cur/prev: 10 starts a run of ones (subtract), 01 ends one (add)
  always_comb begin
    unique case ({cur_bit, prev_bit})
      2'b10:   op = OP_SUB;
      2'b01:   op = OP_ADD;
      default: op = OP_KEEP;
    endcase
  end
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
  import booth_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W:0]   acc,
  input  logic [W-1:0] mcand,
  input  booth_op_e    op,
  output logic [W:0]   res
);
  logic [W:0] mext;
  assign mext = {mcand[W-1], mcand};

  always_comb begin
    unique case (op)
      OP_ADD:  res = acc + mext;
      OP_SUB:  res = acc - mext;
      default: res = acc;
    endcase
  end
endmodule

// File: rtl/booth_step_ctr.sv
module booth_step_ctr #(
  parameter int STEPS = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic advance,
  output logic last
);
  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST_VAL = CW'(STEPS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (load)    cnt_q <= '0;
    else if (advance) cnt_q <= cnt_q + 1'b1;
  end

  assign last = (cnt_q == LAST_VAL);
endmodule

// File: rtl/booth_mul.sv
module booth_mul
  import booth_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] mcand_i,
  input  logic [W-1:0] mplier_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o
);
  // Upper half is kept one bit wider so the most negative multiplicand
  // cannot corrupt the sign before the arithmetic shift.
  logic [W:0]   acc_q;
  logic [W-1:0] mpl_q;
  logic         prev_q;
  logic [W-1:0] mcand_q;
  logic         busy_q, done_q;
  logic [W-1:0] hi_q, lo_q;

  booth_op_e    op;
  logic [W:0]   sum;
  logic [W:0]   acc_n;
  logic [W-1:0] mpl_n;
  logic         last;
  logic         accept;

  assign accept = start && !busy_q;

  booth_recode u_rec (
    .cur_bit  (mpl_q[0]),
    .prev_bit (prev_q),
    .op       (op)
  );

  booth_addsub #(.W(W)) u_as (
    .acc   (acc_q),
    .mcand (mcand_q),
    .op    (op),
    .res   (sum)
  );

  booth_step_ctr #(.STEPS(W)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .advance (busy_q),
    .last    (last)
  );

  assign acc_n = {sum[W], sum[W:1]};
  assign mpl_n = {sum[0], mpl_q[W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      mpl_q   <= '0;
      prev_q  <= 1'b0;
      mcand_q <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      hi_q    <= '0;
      lo_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        acc_q   <= '0;
        mpl_q   <= mplier_i;
        prev_q  <= 1'b0;
        mcand_q <= mcand_i;
        busy_q  <= 1'b1;
      end else if (busy_q) begin
        acc_q  <= acc_n;
        mpl_q  <= mpl_n;
        prev_q <= mpl_q[0];
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          hi_q   <= acc_n[W-1:0];
          lo_q   <= mpl_n;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign hi_o   = hi_q;
  assign lo_o   = lo_q;
endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] hi_o,
  input logic [W-1:0] lo_o
);
  localparam int CW = $clog2(W + 2) + 1;
  localparam logic [CW-1:0] DONE_AT = CW'(W + 1);

  logic [CW-1:0] since_q;

  always_ff @(posedge clk) begin
    if (rst)                  since_q <= '0;
    else if (start && !busy_o) since_q <= CW'(1);
    else if (busy_o)          since_q <= since_q + 1'b1;
  end

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy_o) |=> busy_o);

  p_done_latency_r2: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (since_q == DONE_AT));

  p_done_not_busy_r2: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  p_busy_holds_r5: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> (busy_o || done_o));

  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_result_stable_r6: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(hi_o) && $stable(lo_o)));
endmodule

bind booth_mul booth_mul_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .busy_o (busy_o),
  .done_o (done_o),
  .hi_o   (hi_o),
  .lo_o   (lo_o)
);

// File: tb/tb_booth_mul.sv
module tb_booth_mul;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] mcand_i = '0;
  logic [W-1:0] mplier_i = '0;
  logic         busy_o, done_o;
  logic [W-1:0] hi_o, lo_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  booth_mul #(.W(W)) dut (
    .clk(clk), .rst(rst), .start(start),
    .mcand_i(mcand_i), .mplier_i(mplier_i),
    .busy_o(busy_o), .done_o(done_o), .hi_o(hi_o), .lo_o(lo_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    longint sa, sb;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    return 64'(sa * sb);
  endfunction

  // Drives start for one cycle; returns after the capture edge.
  task automatic kick(input logic [W-1:0] a, input logic [W-1:0] b);
    mcand_i  = a;
    mplier_i = b;
    start    = 1'b1;
    @(negedge clk);
    start    = 1'b0;
  endtask

  // R2, R3, R6: full timing and value check for one multiply
  task automatic t_mul(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    logic [63:0] p;
    p = ref_mul(a, b);
    kick(a, b);
    chk("R2 busy after capture", 64'(busy_o), 64'd1);
    repeat (W - 1) @(negedge clk);
    chk("R2 done not early", 64'(done_o), 64'd0);
    @(negedge clk);
    chk("R2 done at W edges", 64'(done_o), 64'd1);
    chk("R2 busy falls", 64'(busy_o), 64'd0);
    chk(req, {hi_o, lo_o}, p);
    @(negedge clk);
    chk("R6 done one cycle", 64'(done_o), 64'd0);
    chk("R6 result held", {hi_o, lo_o}, p);
  endtask

  task automatic t_reset;
    chk("R1 busy", 64'(busy_o), 64'd0);
    chk("R1 done", 64'(done_o), 64'd0);
    chk("R1 hi/lo", {hi_o, lo_o}, 64'd0);
  endtask

  // R5: a second start mid-run must not disturb the first multiply
  task automatic t_ignore;
    logic [63:0] p;
    p = ref_mul(32'd12345, -32'sd678);
    kick(32'd12345, -32'sd678);
    repeat (5) @(negedge clk);
    kick(32'h7FFF_FFFF, 32'h7FFF_FFFF);
    repeat (W - 7) @(negedge clk);
    chk("R5 no early done", 64'(done_o), 64'd0);
    @(negedge clk);
    chk("R5 done timing kept", 64'(done_o), 64'd1);
    chk("R5 first product kept", {hi_o, lo_o}, p);
    @(negedge clk);
    chk("R5 stays idle", 64'(busy_o), 64'd0);
  endtask

  // R7: restart in the done cycle
  task automatic t_back2back;
    logic [63:0] p;
    p = ref_mul(-32'sd3, 32'd2);
    kick(32'd9, 32'd9);
    repeat (W) @(negedge clk);
    chk("R7 first done", 64'(done_o), 64'd1);
    kick(-32'sd3, 32'd2);
    chk("R7 restart accepted", 64'(busy_o), 64'd1);
    repeat (W) @(negedge clk);
    chk("R7 second done", 64'(done_o), 64'd1);
    chk("R7 second product", {hi_o, lo_o}, p);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mul(32'd2, 32'd7, "R3 2x7");
    t_mul(32'd2, -32'sd3, "R3 2x-3");
    t_mul(-32'sd7, -32'sd7, "R3 -7x-7");
    t_mul(32'hDEAD_BEEF, 32'h1234_5678, "R3 mixed");
    t_mul(32'd0, 32'hFFFF_FFFF, "R3 zero");
    t_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 -1x-1");
    t_mul(32'h7FFF_FFFF, 32'h7FFF_FFFF, "R3 max pos");
    t_mul(32'h8000_0000, 32'h8000_0000, "R4 minneg squared");
    t_mul(32'h8000_0000, 32'd1, "R4 minneg x1");
    t_mul(32'h8000_0000, 32'hFFFF_FFFF, "R4 minneg x-1");
    t_mul(32'd5, 32'h8000_0000, "R4 mult minneg");
    t_ignore();
    t_back2back();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule